// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address for one load, store or instruction fetch at a time. It uses a two-level tree of 4-byte page table entries (PTEs), each level indexed by 10 bits of the virtual page number above a 12-bit page offset. The walker fetches entries through a simple request/response memory port. It applies every leaf validity and permission rule, and it returns the physical address with read, write and execute grants, or it reports a fault.

When the accessed bit of a usable leaf is clear, or a store finds the dirty bit clear, the walker issues a compare-and-swap write. If memory reports that the entry changed before the swap, the walker discards its work and starts again from the root table. In bare mode, and when the effective privilege is machine, no memory access is made and the address passes straight through.

Top module: `vm_walk2`

## Requirements
- R1: After a synchronous reset the walker is idle: `req_ready` is 1, and `res_valid` and `mem_req_valid` are 0.
- R2: When `cfg_paged` is 0, or when the effective privilege is machine (code 3), the result is the zero-extended virtual address with read, write and execute all granted. No memory request is made.
- R3: Privilege codes are 0 user, 1 supervisor, 3 machine. Access kinds are 0 load, 1 store, 2 fetch. For a load or store issued at privilege 3 with `cfg_mprv` set, the effective privilege is `cfg_mpp`. A fetch always uses `cfg_priv`.
- R4: The first PTE read is at `cfg_root_ppn`*4096 + VA[31:22]*4. A valid PTE with R, W and X all clear points to a second table at PPN*4096 + VA[21:12]*4. The PTE bit layout is V=0, R=1, W=2, X=3, U=4, A=6, D=7, with PPN in bits 31:10.
- R5: The walk faults on a PTE with V clear, on a memory response with the error flag set, and on a pointer PTE found at the second level.
- R6: A leaf whose permission bits are W alone, or W and X without R, faults.
- R7: A leaf with U set faults when the effective privilege is not user and either `cfg_sum` is 0 or the access is a fetch. A leaf with U clear faults when the effective privilege is not supervisor.
- R8: A first-level leaf whose PPN bits 9:0 are non-zero faults.
- R9: A load needs R, or X with `cfg_mxr` set. A store needs W. A fetch needs X. Otherwise the walk faults.
- R10: When a usable leaf has A clear, or a store finds D clear, the walker issues a compare-and-swap. Its compare value is the PTE as read, and its write value is that PTE with A set, and with D also set for a store. No write is issued when no bit needs to change.
- R11: If the compare-and-swap returns a value different from the PTE that was read, the walk restarts from the root table.
- R12: The physical address is {PPN, VA[11:0]}. For a first-level leaf, PPN bits 9:0 are replaced by VA[21:12]. The grants are R or (X and MXR) for read, X for execute, and W only when the access is a store or D is set.
- R13: One translation is in flight at a time. `req_ready` is low from acceptance until the result has been shown. `res_valid` is a one-cycle pulse. A memory request is held stable until `mem_req_ready` is seen. A faulting result grants nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| cfg_paged | input | 1 | 1 selects paged mode, 0 selects bare mode |
| cfg_root_ppn | input | 22 | Page number of the root table |
| cfg_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cfg_sum | input | 1 | Supervisor may use user pages for data |
| cfg_mxr | input | 1 | Execute-only pages readable by loads |
| cfg_mprv | input | 1 | Machine data accesses use the previous privilege |
| cfg_mpp | input | 2 | Previous privilege used under `cfg_mprv` |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 selects compare-and-swap, 0 selects read |
| mem_req_addr | output | 34 | PTE byte address |
| mem_req_wdata | output | 32 | Swap value |
| mem_req_cmp | output | 32 | Compare value |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_err | input | 1 | Response carries a bus error |
| mem_rsp_data | input | 32 | Read data, or the old value for a swap |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Translation faulted |
| res_paddr | output | 34 | Physical address |
| res_r | output | 1 | Read granted |
| res_w | output | 1 | Write granted |
| res_x | output | 1 | Execute granted |

## Verification
The bench targets the places where a walker usually goes wrong. A superpage that is misaligned, or correctly aligned, would map to the wrong frame if the low PPN bits were not checked or not replaced. Machine-mode data accesses under MPRV would bypass translation if MPP were ignored, while fetches must still bypass it. A leaf whose W grant is limited by D would hand out write permission that skips the later dirty update. The swap-race case changes the PTE in memory just before the swap. A walker that does not restart would return the stale frame, and one that restarts at the wrong level would issue the wrong number of reads. Randomized tables exercise mixed U/SUM/MXR/privilege combinations, reserved encodings, bus errors and running out of levels. Each case is compared against an independent model of the rules.

// File: rtl/vmw_pkg.sv
package vmw_pkg;
  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // entry flag positions (memory format)
  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int B_A = 6;
  localparam int B_D = 7;
  localparam int PPN_LSB = 10;
endpackage

// File: rtl/vmw_priv_sel.sv
module vmw_priv_sel
  import vmw_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       mprv,
  input  logic [1:0] mpp,
  input  logic [1:0] kind,
  input  logic       paged,
  output logic [1:0] eff_priv,
  output logic       bypass
);
  always_comb begin
    eff_priv = priv;
    if (priv == PRIV_M && kind != KIND_FETCH && mprv)
      eff_priv = mpp;
    bypass = !paged || (eff_priv == PRIV_M);
  end
endmodule

// File: rtl/vmw_leaf_check.sv
module vmw_leaf_check
  import vmw_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             fr,
  input  logic             fw,
  input  logic             fx,
  input  logic             fu,
  input  logic [IDX_W-1:0] ppn_lo,
  input  logic             first_lvl,
  input  logic [1:0]       kind,
  input  logic [1:0]       priv,
  input  logic             sum,
  input  logic             mxr,
  output logic             fault
);
  logic reserved, user_bad, sup_bad, misaligned, perm_bad;

  always_comb begin
    reserved   = fw && !fr;
    user_bad   = fu && (priv != PRIV_U) && (!sum || kind == KIND_FETCH);
    sup_bad    = !fu && (priv != PRIV_S);
    misaligned = first_lvl && (|ppn_lo);
    unique case (kind)
      KIND_LOAD:  perm_bad = !(fr || (fx && mxr));
      KIND_STORE: perm_bad = !fw;
      KIND_FETCH: perm_bad = !fx;
      default:    perm_bad = !fr;
    endcase
    fault = reserved || user_bad || sup_bad || misaligned || perm_bad;
  end
endmodule

// File: rtl/vmw_result_form.sv
module vmw_result_form
  import vmw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int PPN_W = 22,
  parameter int PA_W  = 34
) (
  input  logic [PPN_W-1:0] ppn,
  input  logic             fr,
  input  logic             fw,
  input  logic             fx,
  input  logic             fd,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             first_lvl,
  input  logic [1:0]       kind,
  input  logic             mxr,
  output logic [PA_W-1:0]  paddr,
  output logic             gr,
  output logic             gw,
  output logic             gx
);
  logic [PPN_W-1:0] frame;

  always_comb begin
    frame = ppn;
    if (first_lvl)
      frame[IDX_W-1:0] = vaddr[OFF_W +: IDX_W];
    paddr = {frame, vaddr[OFF_W-1:0]};
    gr = fr || (fx && mxr);
    gx = fx;
    gw = fw && (kind == KIND_STORE || fd);
  end
endmodule

// File: rtl/vm_walk2.sv
module vm_walk2
  import vmw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int PA_W  = 34,
  parameter int PTE_W = 32,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             cfg_paged,
  input  logic [PPN_W-1:0] cfg_root_ppn,
  input  logic [1:0]       cfg_priv,
  input  logic             cfg_sum,
  input  logic             cfg_mxr,
  input  logic             cfg_mprv,
  input  logic [1:0]       cfg_mpp,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  output logic [PTE_W-1:0] mem_req_cmp,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             res_valid,
  output logic             res_fault,
  output logic [PA_W-1:0]  res_paddr,
  output logic             res_r,
  output logic             res_w,
  output logic             res_x
);
  localparam int ENT_SH = $clog2(PTE_W / 8);
  localparam logic [PTE_W-1:0] AD_MASK = (PTE_W'(1) << B_A) | (PTE_W'(1) << B_D);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_CAS_REQ, ST_CAS_WAIT
  } st_e;

  st_e              st;
  logic [VA_W-1:0]  vaddr_q;
  logic [1:0]       kind_q;
  logic [1:0]       priv_q;
  logic             sum_q, mxr_q;
  logic [PPN_W-1:0] root_q, base_q;
  logic             first_q;
  logic [PTE_W-1:0] pte_q, new_pte_q;

  logic [1:0]       eff_priv;
  logic             bypass;
  logic [IDX_W-1:0] cur_idx;
  logic             leaf_fault;
  logic [PTE_W-1:0] fin_pte, upd_pte;
  logic [PA_W-1:0]  fin_paddr;
  logic             fin_r, fin_w, fin_x;
  logic             rsp_ptr, need_upd;

  vmw_priv_sel u_priv (
    .priv(cfg_priv), .mprv(cfg_mprv), .mpp(cfg_mpp), .kind(req_kind),
    .paged(cfg_paged), .eff_priv(eff_priv), .bypass(bypass)
  );

  vmw_leaf_check #(.IDX_W(IDX_W)) u_leaf (
    .fr(mem_rsp_data[B_R]), .fw(mem_rsp_data[B_W]), .fx(mem_rsp_data[B_X]),
    .fu(mem_rsp_data[B_U]), .ppn_lo(mem_rsp_data[PPN_LSB +: IDX_W]),
    .first_lvl(first_q), .kind(kind_q), .priv(priv_q), .sum(sum_q),
    .mxr(mxr_q), .fault(leaf_fault)
  );

  assign fin_pte = (st == ST_CAS_WAIT) ? new_pte_q : mem_rsp_data;

  vmw_result_form #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PPN_W(PPN_W), .PA_W(PA_W)
  ) u_form (
    .ppn(fin_pte[PPN_LSB +: PPN_W]), .fr(fin_pte[B_R]), .fw(fin_pte[B_W]),
    .fx(fin_pte[B_X]), .fd(fin_pte[B_D]), .vaddr(vaddr_q), .first_lvl(first_q),
    .kind(kind_q), .mxr(mxr_q), .paddr(fin_paddr), .gr(fin_r), .gw(fin_w), .gx(fin_x)
  );

  always_comb begin
    cur_idx   = first_q ? vaddr_q[OFF_W+IDX_W +: IDX_W] : vaddr_q[OFF_W +: IDX_W];
    rsp_ptr   = !(mem_rsp_data[B_R] || mem_rsp_data[B_W] || mem_rsp_data[B_X]);
    upd_pte   = mem_rsp_data | (PTE_W'(1) << B_A)
              | ((kind_q == KIND_STORE) ? (PTE_W'(1) << B_D) : '0);
    need_upd  = (upd_pte != mem_rsp_data);
  end

  assign req_ready     = (st == ST_IDLE) && !res_valid;
  assign mem_req_valid = (st == ST_RD_REQ) || (st == ST_CAS_REQ);
  assign mem_req_write = (st == ST_CAS_REQ);
  assign mem_req_addr  = {base_q, {OFF_W{1'b0}}} + PA_W'({cur_idx, {ENT_SH{1'b0}}});
  assign mem_req_wdata = new_pte_q;
  assign mem_req_cmp   = pte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      vaddr_q   <= '0;
      kind_q    <= '0;
      priv_q    <= '0;
      sum_q     <= 1'b0;
      mxr_q     <= 1'b0;
      root_q    <= '0;
      base_q    <= '0;
      first_q   <= 1'b1;
      pte_q     <= '0;
      new_pte_q <= '0;
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_paddr <= '0;
      res_r     <= 1'b0;
      res_w     <= 1'b0;
      res_x     <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            vaddr_q <= req_vaddr;
            kind_q  <= req_kind;
            priv_q  <= eff_priv;
            sum_q   <= cfg_sum;
            mxr_q   <= cfg_mxr;
            root_q  <= cfg_root_ppn;
            base_q  <= cfg_root_ppn;
            first_q <= 1'b1;
            if (bypass) begin
              res_valid <= 1'b1;
              res_fault <= 1'b0;
              res_paddr <= PA_W'(req_vaddr);
              res_r     <= 1'b1;
              res_w     <= 1'b1;
              res_x     <= 1'b1;
            end else begin
              st <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ:  if (mem_req_ready) st <= ST_RD_WAIT;
        ST_CAS_REQ: if (mem_req_ready) st <= ST_CAS_WAIT;
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            pte_q <= mem_rsp_data;
            if (mem_rsp_err || !mem_rsp_data[B_V] || (rsp_ptr && !first_q)
                || (!rsp_ptr && leaf_fault)) begin
              st <= ST_IDLE;
              res_valid <= 1'b1;
              res_fault <= 1'b1;
              res_paddr <= '0;
              {res_r, res_w, res_x} <= 3'b000;
            end else if (rsp_ptr) begin
              base_q  <= mem_rsp_data[PPN_LSB +: PPN_W];
              first_q <= 1'b0;
              st      <= ST_RD_REQ;
            end else if (need_upd) begin
              new_pte_q <= upd_pte;
              st        <= ST_CAS_REQ;
            end else begin
              st <= ST_IDLE;
              res_valid <= 1'b1;
              res_fault <= 1'b0;
              res_paddr <= fin_paddr;
              {res_r, res_w, res_x} <= {fin_r, fin_w, fin_x};
            end
          end
        end
        ST_CAS_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              st <= ST_IDLE;
              res_valid <= 1'b1;
              res_fault <= 1'b1;
              res_paddr <= '0;
              {res_r, res_w, res_x} <= 3'b000;
            end else if (mem_rsp_data != pte_q) begin
              base_q  <= root_q;
              first_q <= 1'b1;
              st      <= ST_RD_REQ;
            end else begin
              st <= ST_IDLE;
              res_valid <= 1'b1;
              res_fault <= 1'b0;
              res_paddr <= fin_paddr;
              {res_r, res_w, res_x} <= {fin_r, fin_w, fin_x};
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R13: memory request held until accepted
  a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R13: result is a single-cycle pulse
  a_r13_res_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R13: no new request accepted while memory traffic is outstanding
  a_r13_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  // R13: a fault grants nothing
  a_r13_fault_no_grant: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_fault |-> !(res_r || res_w || res_x));

  // R6: reserved encodings never reach a write grant without read
  a_r6_w_needs_r: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_fault && res_w |-> res_r);

  // R10: swap only changes A/D and always sets A
  a_r10_swap_ad_only: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_write |->
      (((mem_req_wdata ^ mem_req_cmp) & ~AD_MASK) == '0) && mem_req_wdata[B_A]);
endmodule

// File: tb/tb_vm_walk2.sv
module tb_vm_walk2;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                         FU = 8'h10, FA = 8'h40, FD = 8'h80;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [1:0] req_kind, cfg_priv, cfg_mpp;
  logic cfg_paged, cfg_sum, cfg_mxr, cfg_mprv;
  logic [21:0] cfg_root_ppn;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [33:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_req_cmp;
  logic mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;
  logic res_valid, res_fault, res_r, res_w, res_x;
  logic [33:0] res_paddr;

  int checks = 0;
  int errors = 0;
  int mem_ops = 0;
  logic [31:0] mem [logic [33:0]];
  bit tamper_en = 0;
  logic [31:0] tamper_val;
  int last_ops;

  always #(CLK_PERIOD/2) clk = ~clk;

  vm_walk2 dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .cfg_paged(cfg_paged),
    .cfg_root_ppn(cfg_root_ppn), .cfg_priv(cfg_priv), .cfg_sum(cfg_sum),
    .cfg_mxr(cfg_mxr), .cfg_mprv(cfg_mprv), .cfg_mpp(cfg_mpp),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_cmp(mem_req_cmp),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
    .res_paddr(res_paddr), .res_r(res_r), .res_w(res_w), .res_x(res_x)
  );

  function automatic logic [31:0] rd(input logic [33:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mk(input logic [21:0] ppn, input logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // independent model of the translation rules
  task automatic ref_walk(input logic [31:0] va, input logic [1:0] k, input logic [1:0] pr,
                          input logic pg, input logic [21:0] root, input logic sm,
                          input logic mx, input logic mp, input logic [1:0] mpv,
                          output logic f, output logic [33:0] pa, output logic r,
                          output logic w, output logic x, output logic byp,
                          output logic upd, output logic [33:0] ua, output logic [31:0] uv);
    logic [1:0] e;
    logic [33:0] a;
    logic [31:0] p;
    logic top, bad;
    f = 0; pa = 0; r = 0; w = 0; x = 0; byp = 0; upd = 0; ua = 0; uv = 0;
    e = (pr == 2'd3 && k != 2'd2 && mp) ? mpv : pr;
    if (!pg || e == 2'd3) begin
      pa = {2'b00, va}; r = 1; w = 1; x = 1; byp = 1;
      return;
    end
    top = 1;
    a = {root, 12'h000} + {22'h0, va[31:22], 2'b00};
    if (a[33]) begin f = 1; return; end
    p = rd(a);
    if (!p[0]) begin f = 1; return; end
    if (p[3:1] == 3'b000) begin
      top = 0;
      a = {p[31:10], 12'h000} + {22'h0, va[21:12], 2'b00};
      if (a[33]) begin f = 1; return; end
      p = rd(a);
      if (!p[0] || p[3:1] == 3'b000) begin f = 1; return; end
    end
    bad = (p[3:1] == 3'b010) || (p[3:1] == 3'b110);
    if (p[4] && e != 2'd0 && (!sm || k == 2'd2)) bad = 1;
    if (!p[4] && e != 2'd1) bad = 1;
    if (top && p[19:10] != 10'h0) bad = 1;
    if (k == 2'd0 && !(p[1] || (p[3] && mx))) bad = 1;
    if (k == 2'd1 && !p[2]) bad = 1;
    if (k == 2'd2 && !p[3]) bad = 1;
    if (bad) begin f = 1; return; end
    uv = p | 32'h40 | ((k == 2'd1) ? 32'h80 : 32'h0);
    if (uv != p) begin upd = 1; ua = a; end
    p = uv;
    pa = {p[31:20], top ? va[21:12] : p[19:10], va[11:0]};
    r = p[1] | (p[3] & mx);
    x = p[3];
    w = p[2] & (k == 2'd1 || p[7]);
  endtask

  task automatic xact(input string tag, input logic [31:0] va, input logic [1:0] k,
                      input logic [1:0] pr, input logic pg, input logic [21:0] root,
                      input logic sm, input logic mx, input logic mp, input logic [1:0] mpv,
                      input int exp_f, input bit use_ref);
    logic f, r, w, x, byp, upd;
    logic [33:0] pa, ua;
    logic [31:0] uv;
    int ops0;
    ref_walk(va, k, pr, pg, root, sm, mx, mp, mpv, f, pa, r, w, x, byp, upd, ua, uv);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ops0 = mem_ops;
    req_vaddr = va; req_kind = k; cfg_priv = pr; cfg_paged = pg; cfg_root_ppn = root;
    cfg_sum = sm; cfg_mxr = mx; cfg_mprv = mp; cfg_mpp = mpv;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    last_ops = mem_ops - ops0;
    if (exp_f >= 0) check({tag, " directed fault"}, 64'(res_fault), 64'(exp_f));
    if (use_ref) begin
      check({tag, " fault"}, 64'(res_fault), 64'(f));
      if (!f) begin
        check({tag, " paddr"}, 64'(res_paddr), 64'(pa));
        check({tag, " rwx"}, 64'({res_r, res_w, res_x}), 64'({r, w, x}));
      end
      if (upd) check({tag, " R10 pte update"}, 64'(rd(ua)), 64'(uv));
      if (byp) check({tag, " R2 no memory access"}, 64'(last_ops), 64'd0);
    end
  endtask

  // memory responder: one-cycle latency, random acceptance, swap semantics
  initial begin : responder
    bit pend;
    logic pend_err;
    logic [31:0] pend_data, old;
    pend = 0; pend_err = 0; pend_data = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_err = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      mem_rsp_err = 0;
      if (pend) begin
        mem_rsp_valid = 1; mem_rsp_err = pend_err; mem_rsp_data = pend_data; pend = 0;
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (!rst && mem_req_valid && mem_req_ready) begin
        mem_ops++;
        pend = 1;
        pend_err = mem_req_addr[33];
        if (!mem_req_write) begin
          pend_data = rd(mem_req_addr);
        end else begin
          old = rd(mem_req_addr);
          if (tamper_en) begin
            mem[mem_req_addr] = tamper_val;
            old = tamper_val;
            tamper_en = 0;
          end
          if (old == mem_req_cmp) mem[mem_req_addr] = mem_req_wdata;
          pend_data = old;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [31:0] VA = 32'h0040_3123;
  localparam logic [21:0] RT = 22'h00040;
  localparam logic [33:0] L1A = 34'h40004;
  localparam logic [33:0] L0A = 34'h5000C;

  task automatic two_level(input logic [7:0] fl);
    mem.delete();
    mem[L1A] = mk(22'h50, FV);
    mem[L0A] = mk(22'h123, fl);
  endtask

  initial begin : main
    void'($urandom(32'd20240611));
    rst = 1; req_valid = 0; req_vaddr = 0; req_kind = 0; cfg_priv = 0; cfg_mpp = 0;
    cfg_paged = 0; cfg_sum = 0; cfg_mxr = 0; cfg_mprv = 0; cfg_root_ppn = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 res_valid", 64'(res_valid), 64'd0);
    check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);

    // R2 bare mode
    mem.delete();
    xact("R2 bare", 32'hDEAD_BEEF, 2'd0, 2'd1, 1'b0, RT, 0, 0, 0, 2'd0, 0, 1);
    check("R2 bare paddr", 64'(res_paddr), 64'h0_DEAD_BEEF);
    check("R2 bare ops", 64'(last_ops), 64'd0);

    // R3 MPRV redirects machine data access, not fetch
    two_level(FV | FR | FX | FU | FA | FD);
    xact("R3 mprv load", VA, 2'd0, 2'd3, 1'b1, RT, 0, 0, 1, 2'd0, 0, 1);
    check("R3 mprv walked", 64'(last_ops), 64'd2);
    check("R4 two-level paddr", 64'(res_paddr), 64'h123123);
    xact("R3 mprv fetch bypass", VA, 2'd2, 2'd3, 1'b1, RT, 0, 0, 1, 2'd0, 0, 1);
    check("R3 fetch paddr", 64'(res_paddr), 64'(VA));

    // R10 store sets A and D through one swap
    two_level(FV | FR | FW);
    xact("R10 store", VA, 2'd1, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 0, 1);
    check("R10 store pte", 64'(mem[L0A]), 64'(mk(22'h123, FV | FR | FW | FA | FD)));
    check("R10 store ops", 64'(last_ops), 64'd3);
    check("R12 store w", 64'(res_w), 64'd1);
    // R12 load on clean writable page: no W grant, no swap
    two_level(FV | FR | FW | FA);
    xact("R12 clean load", VA, 2'd0, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 0, 1);
    check("R12 clean load w", 64'(res_w), 64'd0);
    check("R10 no swap", 64'(last_ops), 64'd2);

    // R11 swap race restarts from root
    two_level(FV | FR);
    tamper_en = 1;
    tamper_val = mk(22'h321, FV | FR | FA);
    xact("R11 race", VA, 2'd0, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 0, 0);
    check("R11 race paddr", 64'(res_paddr), 64'h321123);
    check("R11 race ops", 64'(last_ops), 64'd5);
    check("R11 race pte", 64'(mem[L0A]), 64'(tamper_val));

    // R12 superpage, R8 misaligned superpage
    mem.delete();
    mem[L1A] = mk(22'h400, FV | FR | FX | FA);
    xact("R12 superpage", VA, 2'd0, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 0, 1);
    check("R12 superpage paddr", 64'(res_paddr), 64'h403123);
    mem[L1A] = mk(22'h401, FV | FR | FA);
    xact("R8 misaligned", VA, 2'd0, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 1, 1);

    // R6 reserved encodings
    two_level(FV | FW | FA | FD);
    xact("R6 w-only", VA, 2'd1, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 1, 1);
    two_level(FV | FW | FX | FA | FD);
    xact("R6 w+x", VA, 2'd2, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 1, 1);

    // R7 user/supervisor rules
    two_level(FV | FR | FX | FU | FA);
    xact("R7 sup no sum", VA, 2'd0, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 1, 1);
    xact("R7 sup sum", VA, 2'd0, 2'd1, 1'b1, RT, 1, 0, 0, 2'd0, 0, 1);
    xact("R7 sup sum fetch", VA, 2'd2, 2'd1, 1'b1, RT, 1, 0, 0, 2'd0, 1, 1);
    two_level(FV | FR | FA);
    xact("R7 user on sup page", VA, 2'd0, 2'd0, 1'b1, RT, 0, 0, 0, 2'd0, 1, 1);

    // R9 MXR
    two_level(FV | FX | FA);
    xact("R9 exec-only load", VA, 2'd0, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 1, 1);
    xact("R9 mxr load", VA, 2'd0, 2'd1, 1'b1, RT, 0, 1, 0, 2'd0, 0, 1);
    check("R9 mxr r", 64'(res_r), 64'd1);
    xact("R9 store no W", VA, 2'd1, 2'd1, 1'b1, RT, 0, 1, 0, 2'd0, 1, 1);

    // R5 invalid, out of levels, bus error
    mem.delete();
    xact("R5 invalid root entry", VA, 2'd0, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 1, 1);
    two_level(FV);
    xact("R5 out of levels", VA, 2'd0, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 1, 1);
    mem.delete();
    mem[L1A] = mk(22'h200050, FV);
    xact("R5 bus error", VA, 2'd0, 2'd1, 1'b1, RT, 0, 0, 0, 2'd0, 1, 1);

    // random tables (R4, R7, R9, R12, R13 mixed)
    for (int i = 0; i < 300; i++) begin
      logic [31:0] va;
      logic [21:0] root, ppn;
      logic [33:0] a1, a0;
      logic [7:0] fl;
      logic [1:0] pr, mpv;
      int sel;
      mem.delete();
      va = $urandom;
      root = {1'b0, 21'($urandom)};
      a1 = {root, 12'h000} + {22'h0, va[31:22], 2'b00};
      if ($urandom % 3 == 0) begin
        ppn = {($urandom % 12 == 0) ? 1'b1 : 1'b0, 21'($urandom)};
        mem[a1] = mk(ppn, FV | 8'(($urandom % 2) << 5));
        a0 = {ppn, 12'h000} + {22'h0, va[21:12], 2'b00};
        fl = 8'($urandom); fl[0] = ($urandom % 8) != 0;
        if (!ppn[21]) mem[a0] = mk(22'($urandom), fl);
      end else begin
        ppn = 22'($urandom);
        if ($urandom % 2 == 0) ppn[9:0] = 10'h0;
        fl = 8'($urandom); fl[0] = ($urandom % 8) != 0;
        mem[a1] = mk(ppn, fl);
      end
      sel = $urandom % 3; pr = (sel == 2) ? 2'd3 : 2'(sel);
      sel = $urandom % 3; mpv = (sel == 2) ? 2'd3 : 2'(sel);
      xact("R4/R12 random", va, 2'($urandom % 3), pr, ($urandom % 100) < 85, root,
           1'($urandom), 1'($urandom), 1'($urandom), mpv, -1, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule